// File: doc/BRIEF.md
# Inverse LFSR Substitution Layer

This block reverses a chained, shift-register based byte-substitution stage on the decryption side of a lightweight block cipher datapath. A 128-bit substituted word arrives with a valid strobe. One clock later the block presents the word that the forward substitution started from, with its own valid strobe.

The word is cut into equal lanes of 8, 16 or 32 bits. In the forward direction, lane 0 takes its own input slice as an LFSR seed. Every higher lane takes as its seed its slice XORed with the substituted output of the lane below it. Each lane then runs STEPS LFSR steps. The inverse rewinds each lane by STEPS backward steps to recover that lane's seed. It then XORs away the substituted value of the lane below, which is already present in the input word. Because of this, every lane is undone in parallel, in one combinational pass ahead of the output register.

The lane width, the register form (Fibonacci or Galois) and the step count are parameters. They must match the forward stage.

Top module: `lfsr_unsub128`

## Requirements
- R1: With lane width W (LANE_W, one of 8, 16, 32), the word holds 128/W lanes. Lane i occupies bits [i*W +: W] of both in_word and out_word.
- R2: Fibonacci form (GALOIS=0). The forward step is n = {s[W-2:0], f}, where f is the XOR of the state bits at tap positions. The tap positions are bits {7,5,4,3} for W=8, {15,13,12,10} for W=16 and {31,21,1,0} for W=32. When in_word is the forward image of x, out_word equals x.
- R3: Galois form (GALOIS=1). The forward step is n = (s<<1) truncated to W bits, XORed with a constant when s[W-1] was 1. The constant is 0x71 for W=8, 0x6801 for W=16 and 0x00400007 for W=32. When in_word is the forward image of x, out_word equals x.
- R4: Lane 0 of the result is lane 0 of in_word rewound by STEPS backward steps. No XOR is applied to it.
- R5: Lane i>0 of the result is lane i of in_word rewound by STEPS backward steps, XORed with lane i-1 of in_word.
- R6: A word accepted with in_valid=1 appears on out_word one clock later, with out_valid=1 in that same cycle.
- R7: In a cycle after in_valid=0, out_valid is 0 and out_word keeps its previous value, whatever in_word carried.
- R8: rst_n low clears out_word and out_valid at once, without waiting for a clock edge.
- R9: The all-zero word maps to the all-zero word. The all-ones word and every other tested word round-trip bit-exactly through forward then inverse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | in_word carries a word to invert |
| in_word | input | 128 | Substituted word |
| out_valid | output | 1 | out_word holds a fresh result |
| out_word | output | 128 | Recovered word |

## Verification
Each accepted word yields its result exactly one rising edge later. The bench drives inputs on the falling edge and samples on the next falling edge, so out_word and out_valid are read after that single register. A cycle with in_valid low is checked in the next cycle, on the same falling-edge schedule, to show the held word and the low valid. The reset clear is sampled one nanosecond after rst_n falls in the middle of a cycle, well before any clock edge. Six instances cover every lane width in both register forms, and each one is fed the forward image computed by the bench's own model.

// File: rtl/lfsr_unsub_pkg.sv
`timescale 1ns/1ps
package lfsr_unsub_pkg;

  // Fibonacci tap mask: bit j set when the polynomial has term x^(j+1).
  function automatic logic [31:0] fib_taps(input int w);
    case (w)
      8:       return 32'h0000_00B8;
      16:      return 32'h0000_B400;
      default: return 32'h8020_0003;
    endcase
  endfunction

  // Galois feedback constant: the polynomial's lower terms, including x^0.
  function automatic logic [31:0] gal_poly(input int w);
    case (w)
      8:       return 32'h0000_0071;
      16:      return 32'h0000_6801;
      default: return 32'h0040_0007;
    endcase
  endfunction

endpackage

// File: rtl/lfsr_unsub_step.sv
`timescale 1ns/1ps
// One backward LFSR step; GALOIS picks the register form.
module lfsr_unsub_step #(
  parameter int W      = 8,
  parameter bit GALOIS = 1'b0
) (
  input  logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  import lfsr_unsub_pkg::*;

  localparam logic [W-1:0] TAPS = W'(fib_taps(W));
  localparam logic [W-1:0] POLY = W'(gal_poly(W));

  logic [W-1:0] redo;

  generate
    if (GALOIS) begin : g_gal
      logic [W-1:0] unfed;
      always_comb begin
        unfed = cur ^ (cur[0] ? POLY : '0);
        prev  = {cur[0], unfed[W-1:1]};
        redo  = {prev[W-2:0], 1'b0} ^ (prev[W-1] ? POLY : '0);
      end
      always_comb begin
        a_r3_gal_undo : assert (redo == cur)
          else $error("galois backward step not undone by forward step");
      end
    end else begin : g_fib
      always_comb begin
        prev = {cur[0] ^ (^(cur[W-1:1] & TAPS[W-2:0])), cur[W-1:1]};
        redo = {prev[W-2:0], ^(prev & TAPS)};
      end
      always_comb begin
        a_r2_fib_undo : assert (redo == cur)
          else $error("fibonacci backward step not undone by forward step");
      end
    end
  endgenerate

endmodule

// File: rtl/lfsr_unsub_lane.sv
`timescale 1ns/1ps
// One lane: rewind STEPS steps, then strip the lower lane's contribution.
module lfsr_unsub_lane #(
  parameter int W       = 8,
  parameter bit GALOIS  = 1'b0,
  parameter int STEPS   = 5,
  parameter bit IS_BASE = 1'b0
) (
  input  logic [W-1:0] sub_in,
  input  logic [W-1:0] below_in,
  output logic [W-1:0] plain_out
);

  logic [W-1:0] chain [STEPS+1];

  assign chain[0] = sub_in;

  generate
    for (genvar k = 0; k < STEPS; k++) begin : g_step
      lfsr_unsub_step #(.W(W), .GALOIS(GALOIS)) step_i (
        .cur  (chain[k]),
        .prev (chain[k+1])
      );
    end
    if (IS_BASE) begin : g_base
      // R4: the lowest lane is its own seed
      assign plain_out = chain[STEPS];
    end else begin : g_upper
      // R5: remove the neighbour's substituted value
      assign plain_out = chain[STEPS] ^ below_in;
    end
  endgenerate

endmodule

// File: rtl/lfsr_unsub128.sv
`timescale 1ns/1ps
module lfsr_unsub128 #(
  parameter int LANE_W = 8,
  parameter bit GALOIS = 1'b0,
  parameter int STEPS  = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [127:0] in_word,
  output logic         out_valid,
  output logic [127:0] out_word
);

  localparam int WORD_W = 128;
  localparam int NLANES = WORD_W / LANE_W;

  // reset: asserted at once, released through two flops
  logic rst_meta_n, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_q_n    <= rst_meta_n;
    end
  end

  logic [WORD_W-1:0] plain_d;

  generate
    for (genvar i = 0; i < NLANES; i++) begin : g_lane
      if (i == 0) begin : g_lo
        lfsr_unsub_lane #(.W(LANE_W), .GALOIS(GALOIS), .STEPS(STEPS), .IS_BASE(1'b1)) lane_i (
          .sub_in    (in_word[0 +: LANE_W]),
          .below_in  ({LANE_W{1'b0}}),
          .plain_out (plain_d[0 +: LANE_W])
        );
      end else begin : g_hi
        lfsr_unsub_lane #(.W(LANE_W), .GALOIS(GALOIS), .STEPS(STEPS), .IS_BASE(1'b0)) lane_i (
          .sub_in    (in_word[i*LANE_W +: LANE_W]),
          .below_in  (in_word[(i-1)*LANE_W +: LANE_W]),
          .plain_out (plain_d[i*LANE_W +: LANE_W])
        );
      end
    end
  endgenerate

  // next-state
  logic              word_en;
  logic [WORD_W-1:0] word_nx;
  logic              valid_nx;

  always_comb begin
    word_en  = in_valid;
    word_nx  = word_en ? plain_d : out_word;
    valid_nx = in_valid;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_word  <= '0;
      out_valid <= 1'b0;
    end else if (!rst_q_n) begin
      out_word  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_word  <= word_nx;
      out_valid <= valid_nx;
    end
  end

  a_r6_valid_next : assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid |=> out_valid)
    else $error("out_valid missing after accepted word");

  a_r7_idle_hold : assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_valid |=> (!out_valid && $stable(out_word)))
    else $error("output changed while idle");

  a_r9_zero_word : assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && in_word == '0) |=> (out_word == '0))
    else $error("zero word did not map to zero");

endmodule

// File: tb/lfsr_unsub128_tb_top.sv
`timescale 1ns/1ps
module lfsr_unsub128_tb_top;

  localparam int NCFG = 6;
  localparam int K    = 5;
  localparam int WS [NCFG] = '{8, 16, 32, 8, 16, 32};
  localparam bit GS [NCFG] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};

  localparam int NVEC = 8;
  localparam logic [127:0] VEC [NVEC] = '{
    128'h0,
    {128{1'b1}},
    128'h1,
    128'h8000_0000_0000_0000_0000_0000_0000_0000,
    128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210,
    128'hA5A5_A5A5_5A5A_5A5A_A5A5_A5A5_5A5A_5A5A,
    128'hDEAD_BEEF_0000_0000_0000_0000_CAFE_F00D,
    128'h00FF_00FF_00FF_00FF_FF00_FF00_FF00_FF00
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [127:0] din  [NCFG];
  logic [127:0] dout [NCFG];
  logic         vout [NCFG];

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  generate
    for (genvar g = 0; g < NCFG; g++) begin : cfg
      lfsr_unsub128 #(.LANE_W(WS[g]), .GALOIS(GS[g]), .STEPS(K)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_word   (din[g]),
        .out_valid (vout[g]),
        .out_word  (dout[g])
      );
    end
  endgenerate

  // reference forward model, written from the requirements
  function automatic logic [31:0] fstep(input logic [31:0] s, input int w, input bit gal);
    logic [31:0] mask, taps, poly;
    mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    taps = (w == 8) ? 32'hB8 : (w == 16) ? 32'hB400 : 32'h8020_0003;
    poly = (w == 8) ? 32'h71 : (w == 16) ? 32'h6801 : 32'h0040_0007;
    if (gal) return ((s << 1) & mask) ^ (s[w-1] ? poly : 32'h0);
    else     return ((s << 1) | {31'h0, ^(s & taps)}) & mask;
  endfunction

  function automatic logic [127:0] fwd(input logic [127:0] x, input int w, input bit gal);
    logic [127:0] res;
    logic [31:0]  mask, below, y;
    mask  = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    res   = '0;
    below = '0;
    for (int i = 0; i < 128 / w; i++) begin
      y = 32'(x >> (i * w)) & mask;
      if (i != 0) y = y ^ below;
      for (int k = 0; k < K; k++) y = fstep(y, w, gal);
      res   = res | (128'(y) << (i * w));
      below = y;
    end
    return res;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply_all(input logic [127:0] x);
    for (int g = 0; g < NCFG; g++) din[g] = fwd(x, WS[g], GS[g]);
    in_valid = 1'b1;
  endtask

  task automatic check_all(input logic [127:0] x, input string tag);
    for (int g = 0; g < NCFG; g++) begin
      chk(vout[g] == 1'b1, "R6 valid after accept", {127'h0, vout[g]}, 128'h1);
      chk(dout[g] == x, GS[g] ? {"R3,R1,R5 galois ", tag} : {"R2,R1,R5 fibonacci ", tag},
          dout[g], x);
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 128'h0, 128'h1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [127:0] x, last;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    for (int g = 0; g < NCFG; g++) din[g] = '0;
    repeat (3) @(negedge clk);
    for (int g = 0; g < NCFG; g++) begin
      chk(dout[g] == '0 && vout[g] == 1'b0, "R8 reset state", dout[g], 128'h0);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // table of vectors, one per cycle, back to back
    for (int v = 0; v < NVEC; v++) begin
      apply_all(VEC[v]);
      @(negedge clk);
      check_all(VEC[v], v == 0 ? "R9 zero word" : v == 1 ? "R9 ones word" :
                        v == 2 ? "R4 lowest lane" : "table");
    end

    // random words
    for (int r = 0; r < 40; r++) begin
      x = {$urandom, $urandom, $urandom, $urandom};
      apply_all(x);
      @(negedge clk);
      check_all(x, "random");
    end
    last = x;

    // R7: idle cycle with changed input
    for (int g = 0; g < NCFG; g++) din[g] = ~din[g];
    in_valid = 1'b0;
    @(negedge clk);
    for (int g = 0; g < NCFG; g++) begin
      chk(vout[g] == 1'b0, "R7 valid low when idle", {127'h0, vout[g]}, 128'h0);
      chk(dout[g] == last, "R7 word held when idle", dout[g], last);
    end
    @(negedge clk);
    for (int g = 0; g < NCFG; g++)
      chk(dout[g] == last, "R7 word still held", dout[g], last);

    // R5: only the top lane of x set, lower lanes zero
    x = 128'h5A00_0000_0000_0000_0000_0000_0000_0000;
    apply_all(x);
    @(negedge clk);
    check_all(x, "R5 top lane only");

    // R8: asynchronous clear in mid-cycle
    in_valid = 1'b0;
    #1.2;
    rst_n = 1'b0;
    #1;
    for (int g = 0; g < NCFG; g++)
      chk(dout[g] == '0 && vout[g] == 1'b0, "R8 async clear", dout[g], 128'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    x = VEC[4];
    apply_all(x);
    @(negedge clk);
    check_all(x, "after reset");
    in_valid = 1'b0;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule